// File: doc/BRIEF.md
# Timed Configuration Byte Readback Unit

This unit sits beside a CPU's program-memory load path and lets software read the device's fuse and lock configuration bytes. Software opens a short readback window by writing a control register with two bits raised together: a readback-select bit and a self-programming-enable bit. While the window is open, a load strobe returns a configuration byte chosen by the low bits of a 16-bit pointer instead of the program-memory byte for that address. Both control bits clear themselves once the read completes, once a store is taken, or once the window runs out.

The window is counted in clock cycles from the control write. Loads are redirected only during the first three cycles. A store is accepted during the first four, and the bits drop after the fourth if nothing arrives. While an EEPROM write is in progress, control writes, redirected loads and stores are all blocked. The configuration inputs mark programmed bits with 1. The returned bytes invert them, so a programmed bit reads as 0.

Top module: `cfgrb_unit`

## Requirements
- R1: After reset, `ctl_bits` reads 2'b00 and `rd_data` reads 8'h00.
- R2: A control write with `ee_busy` low and both `ctl_wsel` and `ctl_wspen` high sets `ctl_bits` to 2'b11 (bit 1 readback-select, bit 0 self-programming enable) on the next edge. A control write with `ee_busy` low and any other pair clears both bits.
- R3: Take the clock edge that accepts the opening write as edge 0. A load at edge 1, 2 or 3 loads the selected configuration byte into `rd_data` at that edge.
- R4: A redirected load clears both control bits at the same edge.
- R5: With no load and no store, `ctl_bits` stays 2'b11 after edges 1 to 3 and reads 2'b00 after edge 4. A load at edge 4 returns the program-memory byte.
- R6: A store at edges 1 to 4 clears both control bits and leaves `rd_data` unchanged.
- R7: Pointer 16'h0000 selects fuse low, 16'h0001 lock, 16'h0002 extended fuse and 16'h0003 fuse high.
- R8: Each returned fuse bit is the inverse of its input bit, where an input of 1 means programmed.
- R9: The lock byte is {6'b111111, ~lock_prog[1], ~lock_prog[0]}.
- R10: While `ee_busy` is high, a control write has no effect. A load inside the window returns the program-memory byte and leaves the window open. A store is ignored.
- R11: When no window is open, a load places `pm_data` in `rd_data`.
- R12: A load in the window with a pointer above 16'h0003 returns 8'hFF and closes the window.
- R13: An opening write while the window is already open restarts the count, so edge 0 moves to that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wsel | input | 1 | Written value of readback-select |
| ctl_wspen | input | 1 | Written value of self-programming enable |
| ptr | input | 16 | Load/store pointer |
| ld_stb | input | 1 | Program-memory load strobe |
| st_stb | input | 1 | Self-programming store strobe |
| ee_busy | input | 1 | EEPROM write in progress |
| pm_data | input | 8 | Program-memory byte at `ptr` |
| fuse_lo_prog | input | 8 | Fuse low bits, 1 = programmed |
| fuse_hi_prog | input | 8 | Fuse high bits, 1 = programmed |
| fuse_ext_prog | input | 8 | Extended fuse bits, 1 = programmed |
| lock_prog | input | 2 | Lock bits, 1 = programmed |
| ctl_bits | output | 2 | Control bits {readback-select, enable} |
| rd_data | output | 8 | Load result register |

## Verification
The hardest cases to reach are the ones that depend on exactly where an event falls inside the cycle-counted window. Examples are a load on the fourth edge, a second opening write that lands mid-window, and an EEPROM-busy pulse that has to block one load but not end the window. The stimulus table places each load a set number of idle edges after the opening write and checks `ctl_bits` after every idle edge. Directed sequences then raise `ee_busy` for exactly one edge inside an open window and issue the restart write on edge 3, so that an extended window proves the count was reset.

// File: rtl/cfgrb_pkg.sv
// Package: shared constants and types for the configuration readback unit.
// Assumes a byte-wide data path and a four-entry configuration space.
package cfgrb_pkg;
    localparam int DATA_W = 8;
    localparam int PTR_W  = 16;
    localparam int LOCK_W = 2;

    // Configuration byte selected by the pointer's low bits.
    typedef enum logic [2:0] {
        SEL_FUSE_LO  = 3'd0,
        SEL_LOCK     = 3'd1,
        SEL_FUSE_EXT = 3'd2,
        SEL_FUSE_HI  = 3'd3,
        SEL_NONE     = 3'd4
    } cfg_sel_e;

    // State of the readback window.
    typedef struct packed {
        logic rdsel;
        logic spen;
    } ctl_bits_t;
endpackage

// File: rtl/cfgrb_window.sv
// Module: cfgrb_window
// Holds the two control bits and the cycle counter of the readback window.
// It opens on an accepted control write and closes on a redirected load, a
// taken store or a timeout. Assumes the control write has priority over
// loads and stores at the same edge.
module cfgrb_window #(
    parameter int LD_LIM = 3,
    parameter int ST_LIM = 4,
    localparam int CNT_W = $clog2(ST_LIM + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_wr,
    input  logic                 ctl_wsel,
    input  logic                 ctl_wspen,
    input  logic                 ld_stb,
    input  logic                 st_stb,
    input  logic                 ee_busy,
    output cfgrb_pkg::ctl_bits_t bits,
    output logic                 redirect
);
    logic [CNT_W-1:0] cnt_q;
    logic             open_w;
    logic             wr_ok;
    logic             open_req;
    logic             st_take;
    logic             ld_in_time;

    assign open_w     = bits.rdsel & bits.spen;
    assign wr_ok      = ctl_wr & ~ee_busy;
    assign open_req   = ctl_wsel & ctl_wspen;
    assign ld_in_time = (32'(cnt_q) < LD_LIM);
    // Purpose: a load is redirected only inside the load limit and when not blocked.
    assign redirect   = open_w & ld_stb & ~ee_busy & ld_in_time;
    assign st_take    = open_w & st_stb & ~ee_busy;

    // Purpose: advance or close the window, or reopen it on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits  <= '0;
            cnt_q <= '0;
        end else if (wr_ok) begin
            bits.rdsel <= open_req;
            bits.spen  <= open_req;
            cnt_q      <= '0;
        end else if (open_w) begin
            if (redirect || st_take || (32'(cnt_q) == ST_LIM - 1)) begin
                bits  <= '0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assert_restart_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && open_req) |=> (bits.rdsel && bits.spen && cnt_q == '0));
    assert_busy_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ee_busy && !open_w) |=> (bits == '0));
    assert_hit_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && !ctl_wr) |=> (bits == '0));
    assert_timeout_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (open_w && !ctl_wr && 32'(cnt_q) == ST_LIM - 1) |=> (bits == '0));
    assert_store_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_take && !ctl_wr) |=> (bits == '0));
endmodule

// File: rtl/cfgrb_select.sv
// Module: cfgrb_select
// Decodes the pointer and builds the returned configuration byte. Inputs
// mark programmed bits with 1, so the returned bytes are the inverses.
// Assumes the upper lock-byte bits are unused and read as 1.
module cfgrb_select (
    input  logic [cfgrb_pkg::PTR_W-1:0]  ptr,
    input  logic [cfgrb_pkg::DATA_W-1:0] fuse_lo_prog,
    input  logic [cfgrb_pkg::DATA_W-1:0] fuse_hi_prog,
    input  logic [cfgrb_pkg::DATA_W-1:0] fuse_ext_prog,
    input  logic [cfgrb_pkg::LOCK_W-1:0] lock_prog,
    output logic [cfgrb_pkg::DATA_W-1:0] cfg_byte
);
    import cfgrb_pkg::*;

    cfg_sel_e          sel;
    logic [DATA_W-1:0] lo_rd, hi_rd, ext_rd, lock_rd;

    // Purpose: per-bit inversion of programmed flags into read values.
    for (genvar b = 0; b < DATA_W; b++) begin : g_inv
        assign lo_rd[b]  = ~fuse_lo_prog[b];
        assign hi_rd[b]  = ~fuse_hi_prog[b];
        assign ext_rd[b] = ~fuse_ext_prog[b];
        if (b < LOCK_W) begin : g_lk
            assign lock_rd[b] = ~lock_prog[b];
        end else begin : g_pad
            assign lock_rd[b] = 1'b1;
        end
    end

    // Purpose: map the pointer value to a configuration selector.
    always_comb begin
        if (ptr[PTR_W-1:2] != '0) sel = SEL_NONE;
        else sel = cfg_sel_e'({1'b0, ptr[1:0]});
    end

    // Purpose: pick the byte for the selector; out of range reads all ones.
    always_comb begin
        unique case (sel)
            SEL_FUSE_LO:  cfg_byte = lo_rd;
            SEL_LOCK:     cfg_byte = lock_rd;
            SEL_FUSE_EXT: cfg_byte = ext_rd;
            SEL_FUSE_HI:  cfg_byte = hi_rd;
            default:      cfg_byte = '1;
        endcase
    end

    // Purpose: check the pad bits of the lock byte and the out-of-range value.
    always_comb begin
        if (ptr == PTR_W'(1))
            assert_lock_pad_R9: assert (cfg_byte[DATA_W-1:LOCK_W] == '1);
        if (ptr[PTR_W-1:2] != '0)
            assert_out_of_range_R12: assert (cfg_byte == '1);
    end
endmodule

// File: rtl/cfgrb_outreg.sv
// Module: cfgrb_outreg
// Load result register. On each load it captures either the configuration
// byte (redirected) or the program-memory byte, and otherwise holds.
module cfgrb_outreg (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ld_stb,
    input  logic                         redirect,
    input  logic [cfgrb_pkg::DATA_W-1:0] cfg_byte,
    input  logic [cfgrb_pkg::DATA_W-1:0] pm_data,
    output logic [cfgrb_pkg::DATA_W-1:0] rd_data
);
    // Purpose: capture the load result.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else if (ld_stb) rd_data <= redirect ? cfg_byte : pm_data;
    end

    assert_normal_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_stb && !redirect) |=> (rd_data == $past(pm_data)));
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_stb |=> $stable(rd_data));
endmodule

// File: rtl/cfgrb_unit.sv
// Module: cfgrb_unit (top)
// Timed configuration byte readback: the window controller, the byte
// selector and the result register. Assumes the program-memory byte for
// `ptr` arrives on `pm_data` in the same cycle as the load strobe.
module cfgrb_unit #(
    parameter int LD_LIM = 3,
    parameter int ST_LIM = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr,
    input  logic        ctl_wsel,
    input  logic        ctl_wspen,
    input  logic [15:0] ptr,
    input  logic        ld_stb,
    input  logic        st_stb,
    input  logic        ee_busy,
    input  logic [7:0]  pm_data,
    input  logic [7:0]  fuse_lo_prog,
    input  logic [7:0]  fuse_hi_prog,
    input  logic [7:0]  fuse_ext_prog,
    input  logic [1:0]  lock_prog,
    output logic [1:0]  ctl_bits,
    output logic [7:0]  rd_data
);
    cfgrb_pkg::ctl_bits_t bits;
    logic                 redirect;
    logic [7:0]           cfg_byte;

    cfgrb_window #(.LD_LIM(LD_LIM), .ST_LIM(ST_LIM)) u_win (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wsel(ctl_wsel),
        .ctl_wspen(ctl_wspen), .ld_stb(ld_stb), .st_stb(st_stb),
        .ee_busy(ee_busy), .bits(bits), .redirect(redirect)
    );

    cfgrb_select u_sel (
        .ptr(ptr), .fuse_lo_prog(fuse_lo_prog), .fuse_hi_prog(fuse_hi_prog),
        .fuse_ext_prog(fuse_ext_prog), .lock_prog(lock_prog), .cfg_byte(cfg_byte)
    );

    cfgrb_outreg u_out (
        .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .redirect(redirect),
        .cfg_byte(cfg_byte), .pm_data(pm_data), .rd_data(rd_data)
    );

    assign ctl_bits = {bits.rdsel, bits.spen};

    assert_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ee_busy && !(ctl_wsel && ctl_wspen)) |=> (ctl_bits == 2'b00));
endmodule

// File: tb/cfgrb_unit_test.sv
// Testbench for cfgrb_unit: a table of timed loads, then directed cases.
module cfgrb_unit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctl_wr, ctl_wsel, ctl_wspen;
    logic [15:0] ptr;
    logic        ld_stb, st_stb, ee_busy;
    logic [7:0]  pm_data;
    logic [7:0]  fuse_lo_prog, fuse_hi_prog, fuse_ext_prog;
    logic [1:0]  lock_prog;
    logic [1:0]  ctl_bits;
    logic [7:0]  rd_data;

    int nvec  = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    cfgrb_unit uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wsel(ctl_wsel),
        .ctl_wspen(ctl_wspen), .ptr(ptr), .ld_stb(ld_stb), .st_stb(st_stb),
        .ee_busy(ee_busy), .pm_data(pm_data), .fuse_lo_prog(fuse_lo_prog),
        .fuse_hi_prog(fuse_hi_prog), .fuse_ext_prog(fuse_ext_prog),
        .lock_prog(lock_prog), .ctl_bits(ctl_bits), .rd_data(rd_data)
    );

    // Program memory model: byte at an address.
    assign pm_data = ptr[7:0] ^ 8'hA5;

    // Table: idle edges between the opening write and the load, pointer, expected byte.
    localparam int NV = 8;
    localparam int          V_IDLE [NV] = '{0, 1, 2, 0, 3, 0, 1, 5};
    localparam logic [15:0] V_PTR  [NV] = '{16'h0000, 16'h0001, 16'h0002, 16'h0003,
                                            16'h0000, 16'h0004, 16'h1234, 16'h0010};
    localparam logic [7:0]  V_EXP  [NV] = '{8'h9D, 8'hFD, 8'hFE, 8'hD8,
                                            8'hA5, 8'hFF, 8'hFF, 8'hB5};

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        ctl_wr = 1'b0; ld_stb = 1'b0; st_stb = 1'b0;
    endtask

    task automatic open_win();
        ctl_wr = 1'b1; ctl_wsel = 1'b1; ctl_wspen = 1'b1;
        tick();
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ctl_wr = 0; ctl_wsel = 0; ctl_wspen = 0; ptr = '0;
        ld_stb = 0; st_stb = 0; ee_busy = 0;
        fuse_lo_prog = 8'h62; fuse_hi_prog = 8'h27; fuse_ext_prog = 8'h01; lock_prog = 2'b10;
        repeat (3) tick();
        rst_n = 1'b1;
        check("R1 ctl after reset", {6'b0, ctl_bits}, 8'h00);
        check("R1 rd after reset", rd_data, 8'h00);

        // Table walk: R3 R5 R7 R8 R9 R11 R12
        for (int i = 0; i < NV; i++) begin
            open_win();
            check("R2 window open", {6'b0, ctl_bits}, 8'h03);
            for (int k = 1; k <= V_IDLE[i]; k++) begin
                tick();
                check("R5 idle window bits", {6'b0, ctl_bits}, (k < 4) ? 8'h03 : 8'h00);
            end
            ptr = V_PTR[i]; ld_stb = 1'b1;
            tick();
            check("R3/R7/R8/R9/R11/R12 load result", rd_data, V_EXP[i]);
            check("R4/R5/R12 window closed", {6'b0, ctl_bits}, 8'h00);
        end

        // R2: a write with one bit only clears the window.
        open_win();
        ctl_wr = 1'b1; ctl_wsel = 1'b1; ctl_wspen = 1'b0;
        tick();
        check("R2 single-bit write clears", {6'b0, ctl_bits}, 8'h00);

        // R10: a control write while busy is ignored.
        ee_busy = 1'b1; ctl_wr = 1'b1; ctl_wsel = 1'b1; ctl_wspen = 1'b1;
        tick();
        ee_busy = 1'b0;
        check("R10 busy write ignored", {6'b0, ctl_bits}, 8'h00);

        // R10: a load while busy is not redirected and leaves the window open.
        open_win();
        ee_busy = 1'b1; ptr = 16'h0000; ld_stb = 1'b1;
        tick();
        check("R10 busy load gives program byte", rd_data, 8'hA5);
        check("R10 busy load keeps window", {6'b0, ctl_bits}, 8'h03);
        ee_busy = 1'b0; ld_stb = 1'b1;
        tick();
        check("R3 load at edge 2 after busy", rd_data, 8'h9D);

        // R10: a store while busy is ignored; R6: a store closes, rd unchanged.
        open_win();
        ee_busy = 1'b1; st_stb = 1'b1;
        tick();
        ee_busy = 1'b0;
        check("R10 busy store ignored", {6'b0, ctl_bits}, 8'h03);
        st_stb = 1'b1;
        tick();
        check("R6 store closes", {6'b0, ctl_bits}, 8'h00);
        check("R6 store leaves rd", rd_data, 8'h9D);

        // R13: reopening at edge 3 restarts the count.
        open_win();
        tick(); tick();
        open_win();
        tick(); tick();
        check("R13 window extended", {6'b0, ctl_bits}, 8'h03);
        ptr = 16'h0003; ld_stb = 1'b1;
        tick();
        check("R13 load after restart", rd_data, 8'hD8);

        // R9 with the other lock pattern; R8 extended fuse inversion.
        lock_prog = 2'b01; open_win();
        ptr = 16'h0001; ld_stb = 1'b1;
        tick();
        check("R9 lock byte", rd_data, 8'hFE);
        fuse_ext_prog = 8'hF0; open_win();
        ptr = 16'h0002; ld_stb = 1'b1;
        tick();
        check("R8 ext fuse inverted", rd_data, 8'h0F);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule